// File: doc/BRIEF.md
# MDIO Management Master with PHY Presence Scan

This block is the management side of an Ethernet PHY link. Software reaches it through three word registers: a control word (MDC divider, enable, two fault bits, idle status), a transaction word (start flag, direction, PHY address, register address, data, acknowledge) and a 32-bit presence map. One two-wire management frame at a time goes out on MDC/MDIO, with MDC derived from the system clock.

Software writes the transaction word with the start flag set. It then reads the word back until the flag drops, and takes the result and the acknowledge from the same word. When no software transaction is waiting, the engine reads register 1 of every PHY address in turn. It sets or clears that address's bit in the presence map from the acknowledge. A map of zero means no PHY answered.

Register offsets on `addr`: 0 control, 1 transaction, 2 presence. A read returns its data in `rdata` one clock after `addr` is presented.

Top module: `mdio_master`

## Requirements
- R1: After reset the control word reads 0x8000_0000 (only the idle bit 31 set), the transaction word reads 0, the presence map reads 0, and MDC and the MDIO output-enable are low.
- R2: With enable (control bit 30) clear, MDC stays low. With it set, MDC has a period of max(div,1)+1 clocks and is high for the last period-floor(period/2) clocks of each period, where div is control bits [7:0].
- R3: A read frame on MDIO is 32 ones, then 01, then opcode 10, the 5-bit PHY address and the 5-bit register address (MSB first), then turnaround and 16 data bits. The transaction word holds register address in [25:21], PHY address in [20:16] and data in [15:0].
- R4: With direction bit 30 of the transaction word set, the frame uses opcode 01 and drives turnaround 10 and then the 16 data bits from [15:0]. On completion the acknowledge bit 29 reads 0.
- R5: MDIO and its output-enable change only on the clock edge where MDC falls. The line is sampled on the edge where MDC rises.
- R6: In a read frame the output-enable is low for both turnaround bits and all data bits. On completion the 16 sampled bits appear in [15:0], and bit 29 is 1 exactly when the PHY drove the second turnaround bit low.
- R7: Writing the transaction word with bit 31 set starts a transaction. Bit 31 reads 1 until the frame ends and then clears by itself. A write to the transaction word while bit 31 reads 1 changes nothing and starts nothing.
- R8: A read from an address where nothing answers completes with bit 29 = 0 and data 0xFFFF (line pulled high).
- R9: The presence map bit i equals the acknowledge of the latest scan read of register 1 at PHY address i. Once every address has been scanned, it reads 0 when no PHY is present.
- R10: Control bits [7:0], 30, 19 (fault) and 18 (fault enable) read back as last written.
- R11: A waiting software transaction starts at the first frame boundary, ahead of the next scan read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for `addr` |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output-enable (high drives the line) |
| mdio_i | input | 1 | MDIO line value (pulled high when nobody drives) |

## Verification
The assertions assume that enable is not cleared in the middle of a frame. They also assume that the MDIO input is only changed by the PHY between a falling and the next rising MDC, and that MDC is taken only from this block. The bench keeps to this: enable is only cleared before the first frame, and its PHY model changes its drive only on falling MDC. The divider is changed while frames run, but never to a value that breaks those edge rules. Write-while-busy stimulus is issued only while the start bit is known to be set.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W  = 5;
  localparam int REG_W  = 5;
  localparam int DATA_W = 16;
  localparam int WORD_W = 32;
  localparam int HDR_BITS = 32;

  localparam logic [1:0] ADR_CTRL  = 2'd0;
  localparam logic [1:0] ADR_USER  = 2'd1;
  localparam logic [1:0] ADR_ALIVE = 2'd2;

  localparam int CTRL_IDLE  = 31;
  localparam int CTRL_EN    = 30;
  localparam int CTRL_FAULT = 19;
  localparam int CTRL_FEN   = 18;
  localparam int USER_GO    = 31;
  localparam int USER_WR    = 30;
  localparam int USER_ACK   = 29;
  localparam int USER_REG_LO = 21;
  localparam int USER_PHY_LO = 16;

  localparam logic [REG_W-1:0] SCAN_REG = 5'd1;

  typedef struct packed {
    logic              wr;
    logic [PHY_W-1:0]  phy;
    logic [REG_W-1:0]  rg;
    logic [DATA_W-1:0] data;
  } mdio_req_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic [DIV_W:0]   lim_p1;
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] cnt_nx;

  always_comb begin
    lim     = (div == '0) ? DIV_W'(1) : div;
    lim_p1  = {1'b0, lim} + 1'b1;
    half    = lim_p1[DIV_W:1];
    cnt_nx  = cnt + 1'b1;
    fall_ev = en && (cnt >= lim);
    rise_ev = en && (cnt < lim) && (cnt_nx == half);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (fall_ev) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      if (rise_ev) mdc <= 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_ev,
  input  logic              rise_ev,
  input  logic              req_valid,
  input  mdio_req_t         req,
  output logic              req_take,
  output logic              busy,
  output logic              done,
  output logic              ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int FRAME_LEN = PRE_LEN + HDR_BITS;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] C_END  = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] C_PRE  = CNT_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] C_TA0  = CNT_W'(PRE_LEN + 14);
  localparam logic [CNT_W-1:0] C_TA1  = CNT_W'(PRE_LEN + 15);
  localparam logic [CNT_W-1:0] C_DAT0 = CNT_W'(PRE_LEN + 16);

  logic [CNT_W-1:0]    bcnt;
  logic [CNT_W-1:0]    sidx;
  logic [HDR_BITS-1:0] shreg;
  logic                is_wr;

  assign req_take = fall_ev && !busy && req_valid;
  assign sidx     = bcnt - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      bcnt    <= '0;
      shreg   <= '0;
      is_wr   <= 1'b0;
      done    <= 1'b0;
      ack     <= 1'b0;
      rd_data <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (fall_ev) begin
        if (!busy) begin
          if (req_valid) begin
            busy    <= 1'b1;
            bcnt    <= CNT_W'(1);
            is_wr   <= req.wr;
            ack     <= 1'b0;
            shreg   <= {2'b01, req.wr ? 2'b01 : 2'b10, req.phy, req.rg,
                        req.wr ? 2'b10 : 2'b11,
                        req.wr ? req.data : {DATA_W{1'b1}}};
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b1;
          end
        end else if (bcnt == C_END) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          bcnt <= bcnt + 1'b1;
          if (bcnt < C_PRE) begin
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b1;
          end else begin
            mdio_o  <= shreg[HDR_BITS-1];
            shreg   <= {shreg[HDR_BITS-2:0], 1'b0};
            mdio_oe <= is_wr || (bcnt < C_TA0);
          end
        end
      end else if (rise_ev && busy && !is_wr) begin
        if (sidx == C_TA1) ack <= !mdio_i;
        if (sidx >= C_DAT0) rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int NPHY = 1 << PHY_W;

  logic [DIV_W-1:0]  div_q;
  logic              en_q, fault_q, fen_q;
  logic              go_q, wr_q, ack_q, user_run;
  logic [PHY_W-1:0]  phy_q, scan_ptr;
  logic [REG_W-1:0]  reg_q;
  logic [DATA_W-1:0] data_q;
  logic [NPHY-1:0]   alive_q;
  logic              rise_ev, fall_ev;
  logic              f_take, f_busy, f_done, f_ack;
  logic [DATA_W-1:0] f_data;
  logic              host_user_wr;
  mdio_req_t         req;
  logic [31:0]       rd_mux;

  assign host_user_wr = wr_en && (addr == ADR_USER);

  always_comb begin
    if (go_q) req = '{wr: wr_q, phy: phy_q, rg: reg_q, data: data_q};
    else      req = '{wr: 1'b0, phy: scan_ptr, rg: SCAN_REG, data: '0};
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .en(en_q), .div(div_q),
    .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk(clk), .rst(rst), .fall_ev(fall_ev), .rise_ev(rise_ev),
    .req_valid(1'b1), .req(req), .req_take(f_take), .busy(f_busy),
    .done(f_done), .ack(f_ack), .rd_data(f_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= '0;
      en_q     <= 1'b0;
      fault_q  <= 1'b0;
      fen_q    <= 1'b0;
      go_q     <= 1'b0;
      wr_q     <= 1'b0;
      ack_q    <= 1'b0;
      phy_q    <= '0;
      reg_q    <= '0;
      data_q   <= '0;
      alive_q  <= '0;
      scan_ptr <= '0;
      user_run <= 1'b0;
    end else begin
      if (wr_en && addr == ADR_CTRL) begin
        div_q   <= wdata[DIV_W-1:0];
        en_q    <= wdata[CTRL_EN];
        fault_q <= wdata[CTRL_FAULT];
        fen_q   <= wdata[CTRL_FEN];
      end
      if (host_user_wr && !go_q) begin
        go_q   <= wdata[USER_GO];
        wr_q   <= wdata[USER_WR];
        ack_q  <= 1'b0;
        reg_q  <= wdata[USER_REG_LO +: REG_W];
        phy_q  <= wdata[USER_PHY_LO +: PHY_W];
        data_q <= wdata[DATA_W-1:0];
      end
      if (f_take) user_run <= go_q;
      if (f_done) begin
        if (user_run) begin
          go_q  <= 1'b0;
          ack_q <= f_ack;
          if (!wr_q) data_q <= f_data;
        end else begin
          alive_q[scan_ptr] <= f_ack;
          scan_ptr          <= scan_ptr + 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADR_CTRL: begin
        rd_mux[DIV_W-1:0]  = div_q;
        rd_mux[CTRL_IDLE]  = !f_busy;
        rd_mux[CTRL_EN]    = en_q;
        rd_mux[CTRL_FAULT] = fault_q;
        rd_mux[CTRL_FEN]   = fen_q;
      end
      ADR_USER: begin
        rd_mux[USER_GO]                 = go_q;
        rd_mux[USER_WR]                 = wr_q;
        rd_mux[USER_ACK]                = ack_q;
        rd_mux[USER_REG_LO +: REG_W]    = reg_q;
        rd_mux[USER_PHY_LO +: PHY_W]    = phy_q;
        rd_mux[DATA_W-1:0]              = data_q;
      end
      ADR_ALIVE: rd_mux[NPHY-1:0] = alive_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              en,
  input logic              busy,
  input logic              go,
  input logic              user_run,
  input logic              f_done,
  input logic              wr_user,
  input logic [PHY_W-1:0]  phy_f,
  input logic [REG_W-1:0]  reg_f,
  input logic [DATA_W-1:0] data_f,
  input logic [31:0]       alive
);
  // R5: the line only moves on the falling MDC edge
  assert_drive_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> $fell(mdc));

  // R2: MDC only toggles high while the block is enabled
  assert_mdc_needs_en_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> $past(en));

  // R6: the line is driven only inside a frame
  assert_oe_only_busy_R6: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy);

  // R7: the start flag drops only when a software frame completes
  assert_go_clears_on_done_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(go) |-> $past(f_done && user_run));

  // R7: a write while the start flag is set leaves the fields alone
  assert_ignored_write_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_user && go && !f_done) |=> ($stable(phy_f) && $stable(reg_f) && $stable(data_f)));

  // R9: presence map changes only when a scan frame completes
  assert_alive_on_scan_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(alive) |-> $past(f_done && !user_run));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst(rst), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .en(en_q), .busy(f_busy), .go(go_q), .user_run(user_run), .f_done(f_done),
  .wr_user(host_user_wr), .phy_f(phy_q), .reg_f(reg_q), .data_f(data_q),
  .alive(alive_q)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  mdio_master u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // ---------------- PHY model ----------------
  logic [31:0] present = '0;
  logic [15:0] mem [0:31][0:31];
  logic        drv_en = 1'b0;
  logic        drv_bit = 1'b1;
  logic        inframe = 1'b0;
  int          ones = 0;
  int          k = 0;
  logic [13:0] hdr;
  logic [15:0] wsh;
  logic        op_rd = 1'b0;
  logic [4:0]  m_phy, m_reg;
  logic [1:0]  last_op;
  logic [4:0]  last_phy, last_reg;
  logic [15:0] last_wdat;
  int          nframes = 0;
  int          nuser = 0;
  int          user_idx = 0;

  assign mdio_i = mdio_oe ? mdio_o : (drv_en ? drv_bit : 1'b1);

  function automatic logic [15:0] pat(input int p, input int r);
    return {p[4:0], r[4:0], 6'h2B};
  endfunction

  initial begin
    for (int p = 0; p < 32; p++)
      for (int r = 0; r < 32; r++)
        mem[p][r] = pat(p, r);
  end

  always @(posedge mdc) begin
    if (!inframe) begin
      if (mdio_i) ones = ones + 1;
      else if (ones >= 32) begin
        inframe = 1'b1;
        k = 1;
        hdr = '0;
      end else ones = 0;
    end else begin
      if (k < 14) hdr = {hdr[12:0], mdio_i};
      else if (k >= 16) wsh = {wsh[14:0], mdio_i};
      if (k == 13) begin
        m_phy = hdr[9:5];
        m_reg = hdr[4:0];
        op_rd = (hdr[11:10] == 2'b10);
        nframes = nframes + 1;
        if (m_reg != 5'd1) begin
          last_op  = hdr[11:10];
          last_phy = m_phy;
          last_reg = m_reg;
          nuser    = nuser + 1;
          user_idx = nframes;
        end
      end
      if (k == 31) begin
        if (!op_rd && present[m_phy]) mem[m_phy][m_reg] = wsh;
        if (!op_rd) last_wdat = wsh;
        inframe = 1'b0;
        ones = 0;
      end
      k = k + 1;
    end
  end

  always @(negedge mdc) begin
    if (inframe && op_rd && present[m_phy] && k >= 15 && k <= 31) begin
      drv_en  = 1'b1;
      drv_bit = (k == 15) ? 1'b0 : mem[m_phy][m_reg][31-k];
    end else begin
      drv_en  = 1'b0;
      drv_bit = 1'b1;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic wait_go_clear(output logic [31:0] v);
    v = 32'hFFFF_FFFF;
    for (int i = 0; i < 4000; i++) begin
      reg_rd(2'd1, v);
      if (!v[31]) break;
    end
  endtask

  function automatic logic [31:0] uword(input logic go, input logic wr, input logic ack,
                                        input logic [4:0] r, input logic [4:0] p,
                                        input logic [15:0] d);
    return {go, wr, ack, 3'b000, r, p, d};
  endfunction

  task automatic measure(output int period, output int high);
    logic prev;
    int t;
    period = 0; high = 0;
    prev = mdc;
    for (t = 0; t < 2000; t++) begin
      @(negedge clk);
      if (!prev && mdc) break;
      prev = mdc;
    end
    for (int i = 0; i < 2000; i++) begin
      if (mdc) high++;
      period++;
      @(negedge clk);
      if (!prev && mdc && period > 0 && i > 0) break;
      prev = mdc;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    logic [31:0] v;
    reg_rd(2'd0, v); chk("R1 ctrl reset", v, 32'h8000_0000);
    reg_rd(2'd1, v); chk("R1 user reset", v, 32'h0);
    reg_rd(2'd2, v); chk("R1 alive reset", v, 32'h0);
    chk("R1 mdc low", {31'b0, mdc}, 32'h0);
    chk("R1 oe low", {31'b0, mdio_oe}, 32'h0);
  endtask

  task automatic t_ctrl_rw;
    logic [31:0] v;
    int hi;
    reg_wr(2'd0, 32'h000C_0003);
    reg_rd(2'd0, v); chk("R10 ctrl readback", v, 32'h800C_0003);
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (mdc) hi++;
    end
    chk("R2 mdc low while disabled", hi, 0);
  endtask

  task automatic t_clock;
    int per, hi;
    reg_wr(2'd0, 32'h4000_0004);
    measure(per, hi);
    chk("R2 period div4", per, 5);
    chk("R2 high div4", hi, 3);
    reg_wr(2'd0, 32'h4000_0000);
    measure(per, hi);
    chk("R2 period div0 clamp", per, 2);
    chk("R2 high div0 clamp", hi, 1);
    reg_wr(2'd0, 32'h4000_0001);
  endtask

  task automatic t_scan(input logic [31:0] map, input string tag);
    logic [31:0] v;
    present = map;
    repeat (9000) @(negedge clk);
    reg_rd(2'd2, v);
    chk(tag, v, map);
  endtask

  task automatic t_read_present;
    logic [31:0] v;
    int n0;
    n0 = nframes;
    reg_wr(2'd1, uword(1'b1, 1'b0, 1'b0, 5'd7, 5'd10, 16'h0));
    wait_go_clear(v);
    chk("R6 R7 read result word", v, uword(1'b0, 1'b0, 1'b1, 5'd7, 5'd10, pat(10, 7)));
    chk("R3 read opcode", {30'b0, last_op}, 32'h2);
    chk("R3 read phy/reg", {22'b0, last_phy, last_reg}, {22'b0, 5'd10, 5'd7});
    chk("R11 user frame before next scan", (user_idx <= n0 + 2) ? 1 : 0, 1);
  endtask

  task automatic t_write;
    logic [31:0] v;
    reg_wr(2'd1, uword(1'b1, 1'b1, 1'b0, 5'd4, 5'd16, 16'hBEEF));
    wait_go_clear(v);
    chk("R4 write result word", v, uword(1'b0, 1'b1, 1'b0, 5'd4, 5'd16, 16'hBEEF));
    chk("R4 write opcode", {30'b0, last_op}, 32'h1);
    chk("R4 write data on wire", {16'b0, last_wdat}, {16'b0, 16'hBEEF});
    reg_wr(2'd1, uword(1'b1, 1'b0, 1'b0, 5'd4, 5'd16, 16'h0));
    wait_go_clear(v);
    chk("R4 readback of written reg", v, uword(1'b0, 1'b0, 1'b1, 5'd4, 5'd16, 16'hBEEF));
  endtask

  task automatic t_absent;
    logic [31:0] v;
    reg_wr(2'd1, uword(1'b1, 1'b0, 1'b0, 5'd2, 5'd3, 16'h0));
    wait_go_clear(v);
    chk("R8 absent phy read", v, uword(1'b0, 1'b0, 1'b0, 5'd2, 5'd3, 16'hFFFF));
  endtask

  task automatic t_ignore;
    logic [31:0] v;
    int u0n;
    u0n = nuser;
    reg_wr(2'd1, uword(1'b1, 1'b0, 1'b0, 5'd7, 5'd10, 16'h0));
    reg_wr(2'd1, uword(1'b1, 1'b1, 1'b0, 5'd9, 5'd20, 16'h1234));
    reg_rd(2'd1, v);
    chk("R7 write while busy ignored", v, uword(1'b1, 1'b0, 1'b0, 5'd7, 5'd10, 16'h0));
    wait_go_clear(v);
    chk("R7 busy result word", v, uword(1'b0, 1'b0, 1'b1, 5'd7, 5'd10, pat(10, 7)));
    chk("R7 only one frame started", nuser - u0n, 1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl_rw();
    t_clock();
    t_scan(32'h8000_0025, "R9 alive map A");
    t_scan(32'h0000_0000, "R9 alive map empty");
    t_scan(32'h0001_0402, "R9 alive map B");
    t_read_present();
    t_write();
    t_absent();
    t_ignore();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule